// File: doc/BRIEF.md
# Virtual Address Translation Unit

This block turns a 32-bit virtual address into a physical address for three kinds of access: instruction fetch, data read and data write. Two fixed windows of the address space are never translated. One window drops the top three address bits. The other passes the address through unchanged. All other addresses go through a translation table when translation is enabled, and map straight to their low 29 bits when it is not.

Translation uses a 4-entry fully-associative fetch table in front of a 64-entry unified table. Each entry has its own page size of 1 KB, 4 KB, 64 KB or 1 MB. An entry carries an address-space tag, which a shared flag can override. The entry also holds two protection bits and a dirty bit. A fetch looks in the fetch table first and looks in the unified table only when the fetch table misses. On such a hit the unified entry is copied into the fetch table at a slot index given from outside.

Each request gets a registered answer one cycle later: either success with the physical address, or a single 12-bit fault code. A simple write port fills unified-table entries one index at a time.

Top module: `vat_unit`

## Requirements
- R1: A request (`req_valid` high at a clock edge) produces `rsp_valid` high exactly one cycle later, and only then. On success `rsp_ok` is 1 and `rsp_fault` is 0. On failure `rsp_ok` is 0, `rsp_fault` holds a nonzero code and `rsp_pa` is 0. Access type codes: 00 is read, 01 is write, 10 is fetch, and 11 behaves as a read.
- R2: In privileged mode, addresses 0x80000000..0xBFFFFFFF are never translated and give the physical address {3'b000, va[28:0]}, whatever the enable bit and the table contents.
- R3: In privileged mode, addresses at or above 0xE0000000 pass through unchanged. In user mode, addresses 0xE0000000..0xE3FFFFFF also pass through unchanged.
- R4: A user-mode access to any other untranslated address faults. Reads and fetches give 0x0E0, and writes give 0x100.
- R5: With `mmu_en` low, every remaining address maps to {3'b000, va[28:0]} and is granted with no protection check.
- R6: A table entry matches only if it is valid and va[31:10] equals its page number on the bits above the page offset. Its 8-bit tag must also equal `cur_asid`, unless the entry is shared or (`sv_mode` and `req_priv`) are both high.
- R7: The size code selects the page: 00 is 1 KB, 01 is 4 KB, 10 is 64 KB and 11 is 1 MB. The physical address is {3'b000, ppn, 10'b0} with its page-offset bits cleared, ORed with the page-offset bits of va. Page-number bits below the page size are ignored.
- R8: Two or more matching entries in the table being searched give fault 0x140.
- R9: A table miss gives 0x040 for a read or fetch, and 0x060 for a write. A fetch faults only if both tables miss.
- R10: Protection bit 1 grants user access. A user access to a page with bit 1 clear gives 0x0A0 for a read or fetch, and 0x0C0 for a write.
- R11: Protection bit 0 grants writes. A write to a page with bit 0 clear gives 0x0C0. A permitted write to a page whose dirty bit is clear gives 0x080.
- R12: A fetch that hits the fetch table uses that entry and does not consult the unified table. A fetch that misses it but hits the unified table copies the unified entry into fetch slot `itlb_victim` at the same clock edge. This copy happens even if the fetch then fails its protection check.
- R13: Reset invalidates every entry of both tables. A `ld_en` pulse writes the given fields into unified entry `ld_idx`, and requests see the new entry from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 32 | Virtual address |
| req_type | input | 2 | 00 read, 01 write, 10 fetch |
| req_priv | input | 1 | Privileged mode |
| mmu_en | input | 1 | Translation enable |
| sv_mode | input | 1 | Single-virtual mode: tag ignored while privileged |
| cur_asid | input | 8 | Current address-space tag |
| itlb_victim | input | 2 | Fetch-table slot for a copy |
| ld_en | input | 1 | Unified entry write strobe |
| ld_idx | input | 6 | Unified entry index |
| ld_valid | input | 1 | Entry valid |
| ld_shared | input | 1 | Entry shared (tag ignored) |
| ld_asid | input | 8 | Entry tag |
| ld_vpn | input | 22 | Virtual page number, va[31:10] |
| ld_ppn | input | 19 | Physical page number, pa[28:10] |
| ld_size | input | 2 | Page size code |
| ld_prot | input | 2 | bit1 user access, bit0 write access |
| ld_dirty | input | 1 | Dirty bit |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | Translation granted |
| rsp_fault | output | 12 | Fault code, 0 on success |
| rsp_pa | output | 32 | Physical address |

## Verification
The bench first sends addresses from each window in privileged and user modes, with translation on and off. This separates the two untranslated windows, the user window that is allowed, and the low-29-bit fallback. It then walks pages of all four sizes with offsets at both page edges. Tag variations (equal, unequal, shared, single-virtual while privileged versus user) separate the match rule from the size mask. Overlapping entries, protection-bit and dirty-bit combinations, and each of the three access types bring out every fault code. Finally, a unified entry is changed after it has been copied, which shows whether a fetch was served by the fetch table or the unified table and which fetch slot a copy replaced.

// File: rtl/vat_pkg.sv
package vat_pkg;

  localparam int ASID_W = 8;
  localparam int VPN_W  = 22;
  localparam int PPN_W  = 19;

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [1:0]        size;
    logic [1:0]        prot;
    logic              dirty;
  } tlb_ent_t;

  localparam logic [1:0] ACC_READ  = 2'b00;
  localparam logic [1:0] ACC_WRITE = 2'b01;
  localparam logic [1:0] ACC_FETCH = 2'b10;

  localparam logic [11:0] FLT_MISS_RD   = 12'h040;
  localparam logic [11:0] FLT_MISS_WR   = 12'h060;
  localparam logic [11:0] FLT_FIRST_WR  = 12'h080;
  localparam logic [11:0] FLT_PROT_RD   = 12'h0A0;
  localparam logic [11:0] FLT_PROT_WR   = 12'h0C0;
  localparam logic [11:0] FLT_REGION_RD = 12'h0E0;
  localparam logic [11:0] FLT_REGION_WR = 12'h100;
  localparam logic [11:0] FLT_MULTI     = 12'h140;

  // In-page offset mask for a size code
  function automatic logic [31:0] page_off(input logic [1:0] sz);
    case (sz)
      2'b00:   page_off = 32'h0000_03FF;
      2'b01:   page_off = 32'h0000_0FFF;
      2'b10:   page_off = 32'h0000_FFFF;
      default: page_off = 32'h000F_FFFF;
    endcase
  endfunction

  // Page-number bits that take part in the compare
  function automatic logic [VPN_W-1:0] vpn_cmp_mask(input logic [1:0] sz);
    logic [31:0] off;
    off = page_off(sz);
    vpn_cmp_mask = ~off[31:10];
  endfunction

  function automatic logic [31:0] form_pa(input tlb_ent_t e, input logic [31:0] va);
    logic [31:0] off;
    off = page_off(e.size);
    form_pa = ({3'b000, e.ppn, 10'b0} & ~off) | (va & off);
  endfunction

endpackage

// File: rtl/vat_match.sv
module vat_match
  import vat_pkg::*;
#(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  tlb_ent_t          ents [N],
  input  logic [31:0]       va,
  input  logic [ASID_W-1:0] asid,
  input  logic              ign_asid,
  output logic              hit_any,
  output logic              hit_multi,
  output tlb_ent_t          hit_ent
);

  logic [N-1:0] hits;
  logic [IW-1:0] hit_idx;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic page_eq, tag_ok;
    assign page_eq = ((va[31:10] ^ ents[i].vpn) & vpn_cmp_mask(ents[i].size)) == '0;
    assign tag_ok  = ents[i].shared || ign_asid || (ents[i].asid == asid);
    assign hits[i] = ents[i].valid && page_eq && tag_ok;
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++)
      if (hits[i]) hit_idx = IW'(i);
  end

  assign hit_any   = |hits;
  assign hit_multi = |(hits & (hits - 1'b1));
  assign hit_ent   = ents[hit_idx];

endmodule

// File: rtl/vat_region.sv
module vat_region (
  input  logic [31:0] va,
  input  logic        priv,
  input  logic        is_write,
  output logic        bypass,
  output logic        fault,
  output logic [11:0] fault_code,
  output logic [31:0] pass_pa
);

  logic low_win, top_win, user_ok;

  assign low_win = (va[31:30] == 2'b10);
  assign top_win = (va[31:29] == 3'b111);
  assign user_ok = top_win && (va[28:26] == 3'b000);

  assign bypass     = low_win || top_win;
  assign fault      = bypass && !priv && !user_ok;
  assign fault_code = is_write ? vat_pkg::FLT_REGION_WR : vat_pkg::FLT_REGION_RD;
  assign pass_pa    = low_win ? {3'b000, va[28:0]} : va;

endmodule

// File: rtl/vat_unit.sv
module vat_unit
  import vat_pkg::*;
#(
  parameter int ITLB_N = 4,
  parameter int UTLB_N = 64,
  localparam int IW = $clog2(ITLB_N),
  localparam int UW = $clog2(UTLB_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [31:0]       req_va,
  input  logic [1:0]        req_type,
  input  logic              req_priv,
  input  logic              mmu_en,
  input  logic              sv_mode,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [IW-1:0]     itlb_victim,
  input  logic              ld_en,
  input  logic [UW-1:0]     ld_idx,
  input  logic              ld_valid,
  input  logic              ld_shared,
  input  logic [ASID_W-1:0] ld_asid,
  input  logic [VPN_W-1:0]  ld_vpn,
  input  logic [PPN_W-1:0]  ld_ppn,
  input  logic [1:0]        ld_size,
  input  logic [1:0]        ld_prot,
  input  logic              ld_dirty,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [11:0]       rsp_fault,
  output logic [31:0]       rsp_pa
);

  tlb_ent_t itlb [ITLB_N];
  tlb_ent_t utlb [UTLB_N];

  logic     is_write, is_fetch, ign_asid;
  logic     rg_bypass, rg_fault;
  logic [11:0] rg_code;
  logic [31:0] rg_pa;
  logic     i_hit, i_multi, u_hit, u_multi;
  tlb_ent_t i_ent, u_ent;

  assign is_write = (req_type == ACC_WRITE);
  assign is_fetch = (req_type == ACC_FETCH);
  assign ign_asid = sv_mode && req_priv;

  vat_region u_region (
    .va(req_va), .priv(req_priv), .is_write(is_write),
    .bypass(rg_bypass), .fault(rg_fault), .fault_code(rg_code), .pass_pa(rg_pa)
  );

  vat_match #(.N(ITLB_N)) u_imatch (
    .ents(itlb), .va(req_va), .asid(cur_asid), .ign_asid(ign_asid),
    .hit_any(i_hit), .hit_multi(i_multi), .hit_ent(i_ent)
  );

  vat_match #(.N(UTLB_N)) u_umatch (
    .ents(utlb), .va(req_va), .asid(cur_asid), .ign_asid(ign_asid),
    .hit_any(u_hit), .hit_multi(u_multi), .hit_ent(u_ent)
  );

  // Lookup decision
  logic        nx_ok, copy_en;
  logic [11:0] nx_fault;
  logic [31:0] nx_pa;

  always_comb begin
    nx_ok    = 1'b0;
    nx_fault = '0;
    nx_pa    = '0;
    copy_en  = 1'b0;
    if (rg_bypass) begin
      if (rg_fault) nx_fault = rg_code;
      else begin
        nx_ok = 1'b1;
        nx_pa = rg_pa;
      end
    end else if (!mmu_en) begin
      nx_ok = 1'b1;
      nx_pa = {3'b000, req_va[28:0]};
    end else if (is_fetch) begin
      if (i_multi) nx_fault = FLT_MULTI;
      else if (i_hit) begin
        if (!req_priv && !i_ent.prot[1]) nx_fault = FLT_PROT_RD;
        else begin
          nx_ok = 1'b1;
          nx_pa = form_pa(i_ent, req_va);
        end
      end else if (u_multi) nx_fault = FLT_MULTI;
      else if (u_hit) begin
        copy_en = 1'b1;
        if (!req_priv && !u_ent.prot[1]) nx_fault = FLT_PROT_RD;
        else begin
          nx_ok = 1'b1;
          nx_pa = form_pa(u_ent, req_va);
        end
      end else nx_fault = FLT_MISS_RD;
    end else begin
      if (u_multi) nx_fault = FLT_MULTI;
      else if (u_hit) begin
        if (!req_priv && !u_ent.prot[1])
          nx_fault = is_write ? FLT_PROT_WR : FLT_PROT_RD;
        else if (is_write && !u_ent.prot[0]) nx_fault = FLT_PROT_WR;
        else if (is_write && !u_ent.dirty)   nx_fault = FLT_FIRST_WR;
        else begin
          nx_ok = 1'b1;
          nx_pa = form_pa(u_ent, req_va);
        end
      end else nx_fault = is_write ? FLT_MISS_WR : FLT_MISS_RD;
    end
  end

  // Table storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < UTLB_N; i++) utlb[i] <= '0;
    end else if (ld_en) begin
      utlb[ld_idx] <= '{valid: ld_valid, shared: ld_shared, asid: ld_asid,
                        vpn: ld_vpn, ppn: ld_ppn, size: ld_size,
                        prot: ld_prot, dirty: ld_dirty};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ITLB_N; i++) itlb[i] <= '0;
    end else if (req_valid && copy_en) begin
      itlb[itlb_victim] <= u_ent;
    end
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_fault <= '0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_ok    <= nx_ok;
        rsp_fault <= nx_fault;
        rsp_pa    <= nx_pa;
      end
    end
  end

endmodule

// File: rtl/vat_unit_chk.sv
module vat_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] req_va,
  input logic        req_priv,
  input logic        mmu_en,
  input logic        rsp_valid,
  input logic        rsp_ok,
  input logic [11:0] rsp_fault,
  input logic [31:0] rsp_pa
);

  // R1
  rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rsp_valid == $past(req_valid)));

  // R1
  ok_code_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ok) |-> (rsp_fault == 12'h000));

  // R1
  fail_code_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ok) |-> (rsp_fault != 12'h000 && rsp_pa == 32'h0));

  // R2
  low_window_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && req_priv && req_va[31:30] == 2'b10))
      |-> (rsp_ok && rsp_pa == {3'b000, $past(req_va[28:0])}));

  // R4
  user_window_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && !req_priv && req_va[31:30] == 2'b10))
      |-> (!rsp_ok && (rsp_fault == 12'h0E0 || rsp_fault == 12'h100)));

  // R5
  mmu_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && !mmu_en && !req_va[31]))
      |-> (rsp_ok && rsp_pa == {3'b000, $past(req_va[28:0])}));

endmodule

bind vat_unit vat_unit_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
  .req_priv(req_priv), .mmu_en(mmu_en), .rsp_valid(rsp_valid),
  .rsp_ok(rsp_ok), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
);

// File: tb/vat_unit_test.sv
`timescale 1ns/1ps
module vat_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [1:0]  req_type = '0;
  logic        req_priv = 1'b0;
  logic        mmu_en = 1'b0;
  logic        sv_mode = 1'b0;
  logic [7:0]  cur_asid = '0;
  logic [1:0]  itlb_victim = '0;
  logic        ld_en = 1'b0;
  logic [5:0]  ld_idx = '0;
  logic        ld_valid = 1'b0, ld_shared = 1'b0, ld_dirty = 1'b0;
  logic [7:0]  ld_asid = '0;
  logic [21:0] ld_vpn = '0;
  logic [18:0] ld_ppn = '0;
  logic [1:0]  ld_size = '0, ld_prot = '0;
  logic        rsp_valid, rsp_ok;
  logic [11:0] rsp_fault;
  logic [31:0] rsp_pa;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vat_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .req_type(req_type), .req_priv(req_priv), .mmu_en(mmu_en),
    .sv_mode(sv_mode), .cur_asid(cur_asid), .itlb_victim(itlb_victim),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_valid(ld_valid), .ld_shared(ld_shared),
    .ld_asid(ld_asid), .ld_vpn(ld_vpn), .ld_ppn(ld_ppn), .ld_size(ld_size),
    .ld_prot(ld_prot), .ld_dirty(ld_dirty), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
  );

  localparam logic [1:0] RD = 2'b00, WR = 2'b01, FE = 2'b10;

  task automatic access(input logic [31:0] va, input logic [1:0] t, input logic pv,
                        input logic [7:0] asid, input logic e_ok, input logic [11:0] e_f,
                        input logic [31:0] e_pa, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_type = t; req_priv = pv; cur_asid = asid;
    @(negedge clk);
    req_valid = 1'b0;
    n_run++;
    if (rsp_valid !== 1'b1 || rsp_ok !== e_ok || rsp_fault !== e_f ||
        rsp_pa !== (e_ok ? e_pa : 32'h0)) begin
      n_fail++;
      $display("FAIL %s va=%h: got v=%b ok=%b f=%h pa=%h, expected ok=%b f=%h pa=%h",
               tag, va, rsp_valid, rsp_ok, rsp_fault, rsp_pa, e_ok, e_f,
               e_ok ? e_pa : 32'h0);
    end
  endtask

  task automatic load(input int idx, input logic v, input logic sh, input logic [7:0] a,
                      input logic [21:0] vpn, input logic [18:0] ppn, input logic [1:0] sz,
                      input logic [1:0] pr, input logic d);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 6'(idx); ld_valid = v; ld_shared = sh; ld_asid = a;
    ld_vpn = vpn; ld_ppn = ppn; ld_size = sz; ld_prot = pr; ld_dirty = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic t_reset();
    n_run++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: rsp_valid=%b expected 0", rsp_valid);
    end
    mmu_en = 1'b1;
    // R13: all entries invalid after reset
    access(32'h0000_1000, RD, 1, 8'h00, 0, 12'h040, 0, "R13 empty tables");
  endtask

  task automatic t_windows();
    mmu_en = 1'b1;
    access(32'h9234_5678, RD, 1, 0, 1, 0, 32'h1234_5678, "R2 low window read");
    access(32'hA000_0004, FE, 1, 0, 1, 0, 32'h0000_0004, "R2 low window fetch");
    access(32'hFF00_0010, WR, 1, 0, 1, 0, 32'hFF00_0010, "R3 top window priv");
    access(32'hE000_0040, WR, 0, 0, 1, 0, 32'hE000_0040, "R3 user allowed window");
    access(32'hE3FF_FFFC, RD, 0, 0, 1, 0, 32'hE3FF_FFFC, "R3 user window edge");
    access(32'h8000_0000, RD, 0, 0, 0, 12'h0E0, 0, "R4 user read");
    access(32'hA000_0000, WR, 0, 0, 0, 12'h100, 0, "R4 user write");
    access(32'hE400_0000, FE, 0, 0, 0, 12'h0E0, 0, "R4 user fetch");
  endtask

  task automatic t_mmu_off();
    mmu_en = 1'b0;
    access(32'h4000_1234, WR, 0, 0, 1, 0, 32'h0000_1234, "R5 off user write");
    access(32'hC000_0100, FE, 0, 0, 1, 0, 32'h0000_0100, "R5 off P3 fetch");
    mmu_en = 1'b1;
  endtask

  task automatic t_miss();
    access(32'h0030_0000, WR, 1, 0, 0, 12'h060, 0, "R9 write miss");
    access(32'h0030_0000, FE, 1, 0, 0, 12'h040, 0, "R9 fetch miss");
  endtask

  task automatic t_match_sizes();
    load(1, 1, 0, 8'h05, 22'h01000, 19'h00124, 2'b01, 2'b11, 1); // 4K
    access(32'h0040_0ABC, RD, 1, 8'h05, 1, 0, 32'h0004_9ABC, "R6 tag equal");
    access(32'h0040_0ABC, RD, 1, 8'h06, 0, 12'h040, 0, "R6 tag differs");
    sv_mode = 1'b1;
    access(32'h0040_0ABC, RD, 1, 8'h06, 1, 0, 32'h0004_9ABC, "R6 single-virtual priv");
    access(32'h0040_0ABC, RD, 0, 8'h06, 0, 12'h040, 0, "R6 single-virtual user");
    sv_mode = 1'b0;
    load(9, 1, 1, 8'h77, 22'h02400, 19'h00008, 2'b00, 2'b11, 1); // shared 1K
    access(32'h0090_0010, RD, 0, 8'h01, 1, 0, 32'h0000_2010, "R6 shared entry");
    load(2, 1, 0, 8'h05, 22'h04000, 19'h00007, 2'b00, 2'b11, 1); // 1K
    access(32'h0100_03FF, RD, 1, 8'h05, 1, 0, 32'h0000_1FFF, "R7 1K top edge");
    access(32'h0100_0400, RD, 1, 8'h05, 0, 12'h040, 0, "R7 1K past page");
    load(3, 1, 0, 8'h05, 22'h0803F, 19'h00040, 2'b10, 2'b11, 1); // 64K, low vpn bits set
    access(32'h0200_FFFC, RD, 1, 8'h05, 1, 0, 32'h0001_FFFC, "R7 64K masked vpn");
    load(4, 1, 0, 8'h05, 22'h10000, 19'h00400, 2'b11, 2'b11, 1); // 1M
    access(32'h040A_BCDE, RD, 1, 8'h05, 1, 0, 32'h001A_BCDE, "R7 1M page");
  endtask

  task automatic t_multi();
    load(5, 1, 0, 8'h05, 22'h01001, 19'h00300, 2'b01, 2'b11, 1); // overlaps idx 1 page
    access(32'h0040_0010, RD, 1, 8'h05, 0, 12'h140, 0, "R8 multiple hit");
    load(5, 0, 0, 8'h05, 22'h01001, 19'h00300, 2'b01, 2'b11, 1);
    access(32'h0040_0010, RD, 1, 8'h05, 1, 0, 32'h0004_9010, "R13 invalidated entry");
  endtask

  task automatic t_prot();
    load(6, 1, 1, 8'h00, 22'h01800, 19'h00010, 2'b01, 2'b01, 1);
    access(32'h0060_0004, RD, 0, 8'h05, 0, 12'h0A0, 0, "R10 user read");
    access(32'h0060_0004, WR, 0, 8'h05, 0, 12'h0C0, 0, "R10 user write");
    itlb_victim = 2'd3;
    access(32'h0060_0004, FE, 0, 8'h05, 0, 12'h0A0, 0, "R10 user fetch");
    access(32'h0060_0004, WR, 1, 8'h05, 1, 0, 32'h0000_4004, "R10 priv write");
    load(7, 1, 0, 8'h05, 22'h01C00, 19'h00020, 2'b01, 2'b10, 1);
    access(32'h0070_0008, WR, 0, 8'h05, 0, 12'h0C0, 0, "R11 read-only write");
    load(8, 1, 0, 8'h05, 22'h02000, 19'h00030, 2'b01, 2'b11, 0);
    access(32'h0080_0008, WR, 1, 8'h05, 0, 12'h080, 0, "R11 clean page write");
    access(32'h0080_0008, RD, 1, 8'h05, 1, 0, 32'h0000_C008, "R11 clean page read");
  endtask

  task automatic t_itlb();
    itlb_victim = 2'd0;
    access(32'h0040_0010, FE, 1, 8'h05, 1, 0, 32'h0004_9010, "R12 fetch copies");
    load(1, 1, 0, 8'h05, 22'h01000, 19'h00200, 2'b01, 2'b11, 1);
    access(32'h0040_0010, FE, 1, 8'h05, 1, 0, 32'h0004_9010, "R12 fetch table first");
    access(32'h0040_0010, RD, 1, 8'h05, 1, 0, 32'h0008_0010, "R12 data uses unified");
    access(32'h0100_0000, FE, 1, 8'h05, 1, 0, 32'h0000_1C00, "R12 copy over slot 0");
    itlb_victim = 2'd1;
    access(32'h0040_0010, FE, 1, 8'h05, 1, 0, 32'h0008_0010, "R12 evicted refetch");
    itlb_victim = 2'd2;
    access(32'h0100_0004, FE, 1, 8'h05, 1, 0, 32'h0000_1C04, "R12 slot 0 kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_windows();
    t_mmu_off();
    t_miss();
    t_match_sizes();
    t_multi();
    t_prot();
    t_itlb();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule